// File: doc/BRIEF.md
# Throttled DMA Request Generator

This block drives the request line of a host DMA channel that empties received frames from a network controller's buffer into system memory. When the receive side reports a completed frame and gives its length in words, the block loads that count. It then holds the request high while more than one word is still waiting. The host controller moves one word on each cycle where both its acknowledge and its read strobe are high. The request falls once the next-to-last word has moved, so no request is pending while the final word goes across. After that word the block is idle and can accept the next frame.

An optional burst limit stops the channel from holding the host bus for long stretches. While the limit is enabled, the request is forced low for a fixed release window after every fixed stretch of asserted request time. The two windows are set as clock-cycle counts by parameters. At a 20 MHz clock, 28 us of active time and 1.3 us of release are 560 and 26 cycles. The active-time count restarts with each new frame. If the limit is switched off during a release window, that window ends in the same cycle.

Top module: `dma_req_gen`

## Requirements
- R1: When a frame of two or more words is accepted in idle, `dma_req` is high from the cycle after the accepting edge. It stays high, with no strobes, for as long as more than one word remains.
- R2: A word is moved on a clock edge where `dma_ack` and `dma_rd` are both high. An acknowledge without a read strobe moves nothing. After word n-1 of an n-word frame has moved, `dma_req` is low. After word n has moved, the block is idle.
- R3: A frame length of zero is ignored and the block stays idle. A one-word frame raises no request and keeps the block busy until that single word has moved.
- R4: `frame_rdy` while a frame is still in progress is ignored. The remaining count is not reloaded.
- R5: With `burst_lim_en` high, the request is high for at most ACTIVE_CYC consecutive cycles. After that it is forced low for RELEASE_CYC cycles, and this pattern repeats while words remain.
- R6: Dropping `burst_lim_en` during a release window raises `dma_req` again in that same cycle. When the limit is enabled again, a full ACTIVE_CYC stretch follows.
- R7: The active-time count restarts at every accepted frame, so each frame begins with a full ACTIVE_CYC stretch.
- R8: While reset is asserted `dma_req` is low. After reset the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_rdy | input | 1 | A completely received frame is waiting |
| frame_words | input | WCNT_W | Length of that frame in words |
| burst_lim_en | input | 1 | Enables periodic forced release of the request |
| dma_ack | input | 1 | DMA acknowledge from the host controller |
| dma_rd | input | 1 | Read strobe from the host controller |
| dma_req | output | 1 | DMA request to the host controller |

## Verification
The bench builds the block with WCNT_W=5, ACTIVE_CYC=8 and RELEASE_CYC=3. These values keep a full active/release period at eleven cycles, so several complete periods fit into a few dozen cycles. Every frame length from 0 to 20 is swept word by word, and the expected request level after each transfer is computed as remaining-words greater than one. The short windows also make it cheap to check the restart of the active count at each new frame and the early exit from a release window, using exact cycle positions.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic {
    TH_RUN = 1'b0,
    TH_REL = 1'b1
  } th_phase_t;
endpackage

// File: rtl/dreq_rst_sync.sv
module dreq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dreq_word_ctr.sv
module dreq_word_ctr #(
  parameter int WCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WCNT_W-1:0] len,
  input  logic              dec,
  output logic [WCNT_W-1:0] count,
  output logic              busy,
  output logic              multi
);
  logic [WCNT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load | dec;
    if (load)     cnt_d = len;
    else if (dec) cnt_d = cnt_q - WCNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign busy  = (cnt_q != '0);
  assign multi = (cnt_q > WCNT_W'(1));
endmodule

// File: rtl/dreq_throttle.sv
module dreq_throttle
  import dma_req_pkg::*;
#(
  parameter int ACTIVE_CYC  = 560,
  parameter int RELEASE_CYC = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic want,
  output logic gate,
  output logic in_rel
);
  localparam int MAXC = (ACTIVE_CYC > RELEASE_CYC) ? ACTIVE_CYC : RELEASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ACT_LAST = CW'(ACTIVE_CYC - 1);
  localparam logic [CW-1:0] REL_LAST = CW'(RELEASE_CYC - 1);

  th_phase_t     ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    upd   = 1'b0;
    if (restart) begin
      upd   = 1'b1;
      ph_d  = TH_RUN;
      cnt_d = '0;
    end else if (ph_q == TH_RUN) begin
      if (en && want) begin
        upd = 1'b1;
        if (cnt_q == ACT_LAST) begin
          ph_d  = TH_REL;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end else begin
      upd = 1'b1;
      if (!en || cnt_q == REL_LAST) begin
        ph_d  = TH_RUN;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= TH_RUN;
      cnt_q <= '0;
    end else if (upd) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign in_rel = (ph_q == TH_REL);
  assign gate   = in_rel & en;
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int WCNT_W      = 12,
  parameter int ACTIVE_CYC  = 560,
  parameter int RELEASE_CYC = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_rdy,
  input  logic [WCNT_W-1:0] frame_words,
  input  logic              burst_lim_en,
  input  logic              dma_ack,
  input  logic              dma_rd,
  output logic              dma_req
);
  logic              rst_sn;
  logic [WCNT_W-1:0] words_left;
  logic              busy, multi, accept, word_move;
  logic              gate, rel_phase;

  dreq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign accept    = frame_rdy & ~busy & (frame_words != '0);
  assign word_move = busy & dma_ack & dma_rd;

  dreq_word_ctr #(.WCNT_W(WCNT_W)) u_words (
    .clk   (clk),
    .rst_n (rst_sn),
    .load  (accept),
    .len   (frame_words),
    .dec   (word_move),
    .count (words_left),
    .busy  (busy),
    .multi (multi)
  );

  dreq_throttle #(
    .ACTIVE_CYC  (ACTIVE_CYC),
    .RELEASE_CYC (RELEASE_CYC)
  ) u_thr (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en      (burst_lim_en),
    .restart (accept),
    .want    (multi),
    .gate    (gate),
    .in_rel  (rel_phase)
  );

  assign dma_req = multi & ~gate;
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int WCNT_W      = 12,
  parameter int ACTIVE_CYC  = 560
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_rdy,
  input logic [WCNT_W-1:0] frame_words,
  input logic              burst_lim_en,
  input logic              dma_ack,
  input logic              dma_rd,
  input logic              dma_req,
  input logic [WCNT_W-1:0] words_left,
  input logic              rel_phase
);
  localparam int RW = $clog2(ACTIVE_CYC + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_q <= '0;
    else if (!(dma_req && burst_lim_en)) run_q <= '0;
    else if (run_q != RW'(ACTIVE_CYC + 1)) run_q <= run_q + RW'(1);
  end

  a_r2_last_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left <= WCNT_W'(1)) |-> !dma_req);

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left != '0 && dma_ack && dma_rd) |=> (words_left == $past(words_left) - WCNT_W'(1)));

  a_r3_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left == '0 && frame_rdy && frame_words == '0) |=> (words_left == '0 && !dma_req));

  a_r4_busy_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left != '0 && frame_rdy && !(dma_ack && dma_rd)) |=> $stable(words_left));

  a_r5_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_phase && burst_lim_en) |-> !dma_req);

  a_r5_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && burst_lim_en) |-> (run_q < RW'(ACTIVE_CYC)));

  a_r6_exit_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(burst_lim_en) && words_left > WCNT_W'(1)) |-> dma_req);
endmodule

bind dma_req_gen dma_req_gen_chk #(
  .WCNT_W     (WCNT_W),
  .ACTIVE_CYC (ACTIVE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .frame_rdy    (frame_rdy),
  .frame_words  (frame_words),
  .burst_lim_en (burst_lim_en),
  .dma_ack      (dma_ack),
  .dma_rd       (dma_rd),
  .dma_req      (dma_req),
  .words_left   (words_left),
  .rel_phase    (rel_phase)
);

// File: tb/dma_req_gen_test.sv
module dma_req_gen_test;
  localparam int W  = 5;
  localparam int A  = 8;
  localparam int RL = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         frame_rdy;
  logic [W-1:0] frame_words;
  logic         burst_lim_en, dma_ack, dma_rd;
  logic         dma_req;
  int           n_cmp = 0;
  int           n_bad = 0;
  logic         done = 1'b0;

  always #2 clk = ~clk;

  dma_req_gen #(.WCNT_W(W), .ACTIVE_CYC(A), .RELEASE_CYC(RL)) uut (
    .clk(clk), .rst_n(rst_n), .frame_rdy(frame_rdy), .frame_words(frame_words),
    .burst_lim_en(burst_lim_en), .dma_ack(dma_ack), .dma_rd(dma_rd), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dma_req=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load(input int n);
    frame_words = W'(n);
    frame_rdy   = 1'b1;
    tick();
    frame_rdy   = 1'b0;
  endtask

  task automatic strobe();
    dma_ack = 1'b1; dma_rd = 1'b1;
    tick();
    dma_ack = 1'b0; dma_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, dma_req=%b expected completion", dma_req);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; frame_rdy = 1'b0; frame_words = '0;
    burst_lim_en = 1'b0; dma_ack = 1'b0; dma_rd = 1'b0;
    repeat (3) tick();
    chk("R8 reset low", dma_req, 1'b0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R8 idle after reset", dma_req, 1'b0);

    // R1 R2 R3: sweep of frame lengths, throttle off
    for (int n = 0; n <= 20; n++) begin
      load(n);
      chk("R1 R3 request after accept", dma_req, n >= 2);
      for (int i = 0; i < 3; i++) begin
        tick();
        chk("R1 holds without strobes", dma_req, n >= 2);
      end
      if (n > 0) begin
        dma_ack = 1'b1;
        tick();
        dma_ack = 1'b0;
        chk("R2 ack alone moves nothing", dma_req, n >= 2);
      end
      for (int k = 1; k <= n; k++) begin
        strobe();
        chk("R2 level after transfer", dma_req, (n - k) > 1);
      end
    end

    // R4: frame_rdy during a transfer is ignored
    load(6);
    tick();
    frame_words = W'(20); frame_rdy = 1'b1;
    tick();
    frame_rdy = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      strobe();
      chk("R4 no reload while busy", dma_req, (6 - k) > 1);
    end
    load(3);
    chk("R4 idle again after frame", dma_req, 1'b1);
    strobe(); strobe(); strobe();

    // R5: periodic release
    burst_lim_en = 1'b1;
    load(31);
    for (int t = 0; t < 3 * (A + RL); t++) begin
      chk("R5 throttle pattern", dma_req, (t % (A + RL)) < A);
      tick();
    end
    // now at t = 33, period offset 0; advance into release
    for (int t = 0; t < A; t++) tick();
    chk("R5 in release", dma_req, 1'b0);

    // R6: disabling ends the release at once
    burst_lim_en = 1'b0;
    #1;
    chk("R6 exit same cycle", dma_req, 1'b1);
    tick();
    chk("R6 stays high while disabled", dma_req, 1'b1);
    burst_lim_en = 1'b1;
    #1;
    chk("R6 full stretch starts", dma_req, 1'b1);
    for (int i = 1; i < A; i++) begin
      tick();
      chk("R6 full stretch", dma_req, 1'b1);
    end
    tick();
    chk("R6 release after full stretch", dma_req, 1'b0);
    burst_lim_en = 1'b0;
    for (int k = 0; k < 31; k++) strobe();
    tick();
    chk("R2 idle after long frame", dma_req, 1'b0);

    // R7: active count restarts per frame
    burst_lim_en = 1'b1;
    load(2);
    for (int i = 0; i < 4; i++) begin
      chk("R7 first frame high", dma_req, 1'b1);
      tick();
    end
    strobe();
    chk("R7 R2 low before last word", dma_req, 1'b0);
    strobe();
    load(31);
    for (int i = 0; i < A; i++) begin
      chk("R7 full stretch for new frame", dma_req, 1'b1);
      tick();
    end
    chk("R7 release after full stretch", dma_req, 1'b0);
    burst_lim_en = 1'b0;
    for (int k = 0; k < 31; k++) strobe();

    done = 1'b1;
    finish_run();
  end
endmodule